// File: doc/BRIEF.md
# Tile Ping-Pong Loader

This block stages parameter tiles for a dual-path (mean and variance) compute array. Parameters arrive as one burst per tile on a valid/ready stream. Each on-chip address holds a mean value and a variance value, and the two arrive back to back. The block writes into one bank while the compute side reads the other bank. One read therefore returns both values of a pair, so the two datapaths advance in lockstep.

A job starts with a pulse on `start` that carries the tile count. The first tile must be fully loaded before the compute side sees a valid tile. After that, the banks exchange roles only when two things are both true: the fill bank holds a complete tile, and the compute side has reported `cmp_done` for the tile it was working on. Whichever side finishes first waits for the other. Once the last tile has been loaded, no further input is accepted. The job ends with the `cmp_done` of the last tile.

Top module: `tile_pingpong_loader`

## Requirements
- R1: After reset, and whenever no job is running, `in_ready`, `tile_valid`, `job_busy`, `swap` and `job_done` are all 0.
- R2: A tile is 2*DEPTH accepted beats, where DEPTH = TOF*TIF*KX*KY. Beats arrive in pairs for addresses 0 to DEPTH-1 in ascending order. The even beat of each pair is the mean and the odd beat is the variance.
- R3: `rd_addr` is sampled at a clock edge. `rd_mean` and `rd_var` show the pair stored at that address of the compute bank after that same edge, which is one cycle of latency.
- R4: `tile_valid` stays 0 until every beat of the first tile has been accepted. `swap` is then 1 for one cycle, and `tile_valid` is 1 from the next edge on.
- R5: While `tile_valid` is 1 and more tiles remain to be loaded, `in_ready` is 1 so that the other bank can refill. Pairs read from the compute bank stay unchanged while that refill goes on.
- R6: From the edge that accepts the last beat of a tile until the swap, `in_ready` is 0.
- R7: A swap happens only in a cycle where the fill bank is full and either no tile is active or `cmp_done` is 1. If `cmp_done` comes before the next tile is full, `tile_valid` drops to 0 and compute stalls until the load completes.
- R8: Once the last tile of the job has been loaded, `in_ready` stays 0. `job_done` is 1 in the cycle of the `cmp_done` for the last tile, and `job_busy` and `tile_valid` are 0 after that edge.
- R9: The following have no effect: `start` while a job is busy, `start` with `job_tiles` = 0, and `cmp_done` while `tile_valid` is 0.
- R10: Cycles with `in_valid` = 0 neither advance the beat order nor write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse |
| job_tiles | input | TCW | Number of tiles in the job, sampled with `start` |
| job_busy | output | 1 | A job is in progress |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted when valid |
| in_data | input | DW | Stream beat (mean or variance, alternating) |
| rd_addr | input | AW | Compute-side pair address |
| rd_mean | output | DW | Mean at `rd_addr`, one cycle later |
| rd_var | output | DW | Variance at `rd_addr`, one cycle later |
| tile_valid | output | 1 | The compute bank holds a tile to work on |
| cmp_done | input | 1 | Compute finished the current tile |
| swap | output | 1 | Bank roles exchange at the end of this cycle |
| job_done | output | 1 | The last tile's compute has been acknowledged |

## Verification
The main flow is tried with three stream patterns:
- An unbroken burst for the first tile, which shows that compute cannot see a partial tile.
- A second burst loaded while the first tile is still being computed, which separates true overlap from a bank being overwritten and shows that the swap waits for `cmp_done`.
- A third burst with valid bubbles and garbage data on the idle cycles, which shows that only accepted beats move the mean/variance order.

The ordering of `cmp_done` against the end of a load is tried both ways, so a stall on the compute side and a stall on the fill side are each observed. A separate single-tile job, with stray `start` and `cmp_done` pulses, shows which requests are ignored.

// File: rtl/pp_pkg.sv
package pp_pkg;

   typedef enum logic {PH_MEAN = 1'b0, PH_VAR = 1'b1} beat_phase_e;

   function automatic int tile_depth(input int tof, input int tif, input int kx, input int ky);
      return tof * tif * kx * ky;
   endfunction

endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
   parameter int DW    = 8,
   parameter int DEPTH = 36,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          wr_mean_en,
   input  logic          wr_var_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_mean,
   output logic [DW-1:0] rd_var
);

   logic [DW-1:0] mean_mem [DEPTH];
   logic [DW-1:0] var_mem  [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_mean_en) mean_mem[wr_addr] <= wr_data;
      if (wr_var_en)  var_mem[wr_addr]  <= wr_data;
      rd_mean <= mean_mem[rd_addr];
      rd_var  <= var_mem[rd_addr];
   end

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
   import pp_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 36,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          job_start,
   input  logic          fill_en,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          wr_mean_en,
   output logic          wr_var_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          tile_loaded
);

   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   beat_phase_e   phase_q;
   logic [AW-1:0] addr_q;
   logic          accept;

   assign in_ready    = fill_en;
   assign accept      = in_valid & fill_en;
   assign wr_mean_en  = accept & (phase_q == PH_MEAN);
   assign wr_var_en   = accept & (phase_q == PH_VAR);
   assign wr_addr     = addr_q;
   assign wr_data     = in_data;
   assign tile_loaded = wr_var_en & (addr_q == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n || job_start) begin
         phase_q <= PH_MEAN;
         addr_q  <= '0;
      end else if (accept) begin
         if (phase_q == PH_MEAN) begin
            phase_q <= PH_VAR;
         end else begin
            phase_q <= PH_MEAN;
            addr_q  <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
         end
      end
   end

   AST_ADDR_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (addr_q <= LAST_ADDR)); // R2

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl #(
   parameter int TCW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [TCW-1:0] job_tiles,
   input  logic           tile_loaded,
   input  logic           cmp_done,
   output logic           job_start,
   output logic           job_busy,
   output logic           fill_en,
   output logic           fill_full,
   output logic           fill_sel,
   output logic           tile_valid,
   output logic           swap,
   output logic           job_done
);

   logic           busy_q;
   logic [TCW-1:0] fills_left_q;
   logic [TCW-1:0] comp_left_q;
   logic           full_q;
   logic           cmp_busy_q;
   logic           sel_q;
   logic           done_ok;

   assign job_start  = start & ~busy_q & (job_tiles != '0);
   assign done_ok    = cmp_done & cmp_busy_q;
   assign swap       = full_q & (~cmp_busy_q | done_ok);
   assign job_done   = done_ok & (comp_left_q == TCW'(1));
   assign fill_en    = busy_q & (fills_left_q != '0) & ~full_q;
   assign job_busy   = busy_q;
   assign fill_full  = full_q;
   assign fill_sel   = sel_q;
   assign tile_valid = cmp_busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         fills_left_q <= '0;
         comp_left_q  <= '0;
         full_q       <= 1'b0;
         cmp_busy_q   <= 1'b0;
         sel_q        <= 1'b0;
      end else if (job_start) begin
         busy_q       <= 1'b1;
         fills_left_q <= job_tiles;
         comp_left_q  <= job_tiles;
         full_q       <= 1'b0;
         cmp_busy_q   <= 1'b0;
         sel_q        <= 1'b0;
      end else begin
         if (tile_loaded) begin
            full_q       <= 1'b1;
            fills_left_q <= fills_left_q - 1'b1;
         end
         if (swap) begin
            full_q     <= 1'b0;
            sel_q      <= ~sel_q;
            cmp_busy_q <= 1'b1;
         end else if (done_ok) begin
            cmp_busy_q <= 1'b0;
         end
         if (done_ok) comp_left_q <= comp_left_q - 1'b1;
         if (job_done) busy_q <= 1'b0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!tile_valid && !fill_en && !swap)); // R1

   AST_SWAP_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> ((sel_q != $past(sel_q)) && tile_valid)); // R7

   AST_END_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({swap, job_done})); // R8

endmodule

// File: rtl/tile_pingpong_loader.sv
module tile_pingpong_loader #(
   parameter int DW  = 8,
   parameter int TOF = 2,
   parameter int TIF = 2,
   parameter int KX  = 3,
   parameter int KY  = 3,
   parameter int TCW = 8,
   localparam int DEPTH = pp_pkg::tile_depth(TOF, TIF, KX, KY),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [TCW-1:0] job_tiles,
   output logic           job_busy,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [DW-1:0]  in_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_mean,
   output logic [DW-1:0]  rd_var,
   output logic           tile_valid,
   input  logic           cmp_done,
   output logic           swap,
   output logic           job_done
);

   if (DW < 1 || TCW < 1) begin : g_bad_width
      $error("tile_pingpong_loader: DW and TCW must be at least 1");
   end
   if (TOF < 1 || TIF < 1 || KX < 1 || KY < 1) begin : g_bad_dims
      $error("tile_pingpong_loader: tile dimensions must be at least 1");
   end
   if (DEPTH < 2 || DEPTH > 4096) begin : g_bad_depth
      $error("tile_pingpong_loader: tile depth must lie in 2..4096");
   end

   logic          job_start;
   logic          fill_en;
   logic          fill_full;
   logic          fill_sel;
   logic          tile_loaded;
   logic          wr_mean_en;
   logic          wr_var_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          cmp_sel_q;
   logic [DW-1:0] bank_mean [2];
   logic [DW-1:0] bank_var  [2];

   pp_swap_ctrl #(.TCW(TCW)) u_swap (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .job_tiles  (job_tiles),
      .tile_loaded(tile_loaded),
      .cmp_done   (cmp_done),
      .job_start  (job_start),
      .job_busy   (job_busy),
      .fill_en    (fill_en),
      .fill_full  (fill_full),
      .fill_sel   (fill_sel),
      .tile_valid (tile_valid),
      .swap       (swap),
      .job_done   (job_done)
   );

   pp_fill_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .job_start  (job_start),
      .fill_en    (fill_en),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .wr_mean_en (wr_mean_en),
      .wr_var_en  (wr_var_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .tile_loaded(tile_loaded)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      pp_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
         .clk       (clk),
         .wr_mean_en(wr_mean_en & (fill_sel == 1'(b))),
         .wr_var_en (wr_var_en  & (fill_sel == 1'(b))),
         .wr_addr   (wr_addr),
         .wr_data   (wr_data),
         .rd_addr   (rd_addr),
         .rd_mean   (bank_mean[b]),
         .rd_var    (bank_var[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cmp_sel_q <= 1'b1;
      else        cmp_sel_q <= ~fill_sel;
   end

   assign rd_mean = bank_mean[cmp_sel_q];
   assign rd_var  = bank_var[cmp_sel_q];

   AST_FULL_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_full |-> !in_ready); // R6

endmodule

// File: tb/tile_pingpong_loader_tb_top.sv
module tile_pingpong_loader_tb_top;

   localparam int DW    = 8;
   localparam int TCW   = 8;
   localparam int DEPTH = 36;
   localparam int AW    = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [TCW-1:0] job_tiles = '0;
   logic           job_busy;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [DW-1:0]  in_data = '0;
   logic [AW-1:0]  rd_addr = '0;
   logic [DW-1:0]  rd_mean;
   logic [DW-1:0]  rd_var;
   logic           tile_valid;
   logic           cmp_done = 1'b0;
   logic           swap;
   logic           job_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit reported = 0;

   always #10 clk = ~clk;

   tile_pingpong_loader dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .job_tiles(job_tiles),
      .job_busy(job_busy), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .rd_addr(rd_addr), .rd_mean(rd_mean), .rd_var(rd_var),
      .tile_valid(tile_valid), .cmp_done(cmp_done), .swap(swap), .job_done(job_done)
   );

   function automatic logic [DW-1:0] exp_mean(input int t, input int a);
      return DW'(t * 64 + a);
   endfunction

   function automatic logic [DW-1:0] exp_var(input int t, input int a);
      return ~exp_mean(t, a);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      end
      $finish;
   endtask

   task automatic begin_job(input int n);
      @(negedge clk);
      start = 1'b1;
      job_tiles = TCW'(n);
      @(negedge clk);
      start = 1'b0;
   endtask

   // R2 / R10: mean then variance per address, optional bubbles with junk data
   task automatic push_tile(input int t, input bit gaps);
      for (int beat = 0; beat < 2 * DEPTH; beat++) begin
         @(negedge clk);
         if (gaps && (beat % 3 == 1)) begin
            in_valid = 1'b0;
            in_data  = 8'hEE;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = (beat % 2 == 0) ? exp_mean(t, beat / 2) : exp_var(t, beat / 2);
         while (!in_ready) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'hEE;
   endtask

   task automatic read_chk(input int t, input int a, input string req);
      rd_addr = AW'(a);
      @(negedge clk);
      chk({req, " mean"}, int'(rd_mean), int'(exp_mean(t, a)));
      chk({req, " var"},  int'(rd_var),  int'(exp_var(t, a)));
   endtask

   task automatic pulse_done(output bit saw_swap, output bit saw_end);
      @(negedge clk);
      cmp_done = 1'b1;
      #1;
      saw_swap = swap;
      saw_end  = job_done;
      @(negedge clk);
      cmp_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 in_ready",   int'(in_ready), 0);
      chk("R1 tile_valid", int'(tile_valid), 0);
      chk("R1 job_busy",   int'(job_busy), 0);
      chk("R1 swap",       int'(swap), 0);
      chk("R1 job_done",   int'(job_done), 0);
   endtask

   task automatic t_main_flow();
      bit sw, en;
      begin_job(3);
      chk("R4 ready after start", int'(in_ready), 1);
      chk("R4 no tile before load", int'(tile_valid), 0);
      push_tile(0, 1'b0);
      chk("R4 swap after first load", int'(swap), 1);
      chk("R4 tile_valid still low", int'(tile_valid), 0);
      chk("R6 ready low when full", int'(in_ready), 0);
      @(negedge clk);
      chk("R4 tile_valid raised", int'(tile_valid), 1);
      chk("R5 refill ready", int'(in_ready), 1);
      for (int a = 0; a < DEPTH; a++) read_chk(0, a, "R3 tile0");
      push_tile(1, 1'b0);
      chk("R5 tile kept during refill", int'(tile_valid), 1);
      chk("R7 no swap without done", int'(swap), 0);
      chk("R6 full stall", int'(in_ready), 0);
      repeat (3) @(negedge clk);
      chk("R6 stall holds", int'(in_ready), 0);
      read_chk(0, 5, "R5 compute bank unchanged");
      read_chk(0, DEPTH - 1, "R5 compute bank unchanged");
      pulse_done(sw, en);
      chk("R7 swap with done", int'(sw), 1);
      chk("R8 no end mid-job", int'(en), 0);
      chk("R7 tile_valid after swap", int'(tile_valid), 1);
      chk("R5 ready after swap", int'(in_ready), 1);
      read_chk(1, 0, "R7 tile1");
      read_chk(1, 17, "R7 tile1");
      read_chk(1, DEPTH - 1, "R7 tile1");
      pulse_done(sw, en);
      chk("R7 no swap while loading", int'(sw), 0);
      chk("R7 compute stalls", int'(tile_valid), 0);
      chk("R7 fill continues", int'(in_ready), 1);
      push_tile(2, 1'b1);
      chk("R7 swap when load ends", int'(swap), 1);
      @(negedge clk);
      chk("R7 tile2 valid", int'(tile_valid), 1);
      chk("R8 no fill after last", int'(in_ready), 0);
      for (int a = 0; a < DEPTH; a++) read_chk(2, a, "R10 tile2 with bubbles");
      chk("R8 still no fill", int'(in_ready), 0);
      chk("R8 busy before end", int'(job_busy), 1);
      pulse_done(sw, en);
      chk("R8 job_done", int'(en), 1);
      chk("R8 busy cleared", int'(job_busy), 0);
      chk("R8 tile_valid cleared", int'(tile_valid), 0);
      chk("R1 idle ready", int'(in_ready), 0);
   endtask

   task automatic t_ignored();
      bit sw, en;
      pulse_done(sw, en);
      chk("R9 done when idle", int'(en), 0);
      chk("R9 idle stays idle", int'(job_busy), 0);
      begin_job(0);
      chk("R9 zero-tile start", int'(job_busy), 0);
      chk("R9 zero-tile ready", int'(in_ready), 0);
      begin_job(1);
      chk("R9 one-tile start", int'(job_busy), 1);
      pulse_done(sw, en);
      chk("R9 done without tile", int'(en), 0);
      begin_job(5);
      push_tile(3, 1'b0);
      chk("R4 single swap", int'(swap), 1);
      @(negedge clk);
      chk("R8 single no more fill", int'(in_ready), 0);
      read_chk(3, 0, "R3 tile3");
      read_chk(3, 11, "R3 tile3");
      pulse_done(sw, en);
      chk("R9 busy start ignored, one tile ends job", int'(en), 1);
      chk("R9 job over", int'(job_busy), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_main_flow();
      t_ignored();
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

endmodule